// File: doc/BRIEF.md
# Multi-hop Router Input Port with Latch Bypass

This block sits on one input of a router in a network where a flit can cross several routers in a single cycle. When such a traversal ends at this router, the arriving flit is captured in a one-entry latch stage at the end of that cycle. In the cycle after that, the port decides where the flit goes. It can leave again at once toward the crossbar, skipping the packet buffer. Otherwise it is written into a small FIFO packet buffer, which later drains either onward or to the local core.

The decision depends on three things: whether the next circuit segment is granted to this port, whether the downstream router's on/off line is on, and whether the flit is addressed to this router. A flit stops in the buffer when any of these blocks it. Buffered flits leave first, so a flit never overtakes an older one. The port drives its own registered on/off line to the upstream router. This value is worked out one cycle ahead from the buffer occupancy that will exist after the current cycle, so the line can never cause the buffer to overflow.

Top module: `hop_inport`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `up_on` is 1, `fwd_valid` is 0 and `loc_valid` is 0. Reset empties both the latch and the buffer.
- R2: A flit presented with `in_valid`=1 in cycle t is latched at the end of t. In cycle t+1 it is forwarded on `fwd_*` with `fwd_from_buf`=0 if all of the following hold: the buffer is empty, `in_here` was 0, `seg_ready`=1 and `dn_on`=1.
- R3: If `seg_ready` is 0 when a latched flit would otherwise bypass, the flit is written into the buffer. It later leaves on `fwd_*` with `fwd_from_buf`=1 in the first cycle in which it is at the buffer head and `seg_ready`=1 and `dn_on`=1.
- R4: While `dn_on` is 0, `fwd_valid` is 0. A latched flit that arrives in such a cycle is buffered and is not lost.
- R5: A flit latched with `in_here`=1 is always written into the buffer and never appears on `fwd_*`. It leaves on `loc_*` in the first cycle in which it is at the buffer head and `loc_ready`=1.
- R6: While the buffer holds flits, a latched flit is written behind them even if the segment is free. The buffer head is served first, so flits leave in arrival order.
- R7: `up_on` is a register. It is loaded with 1 when the number of free buffer slots after the current cycle is greater than 1, and with 0 otherwise. An upstream sender that sends only in cycles where `up_on` reads 1 can never overflow the buffer: with DEPTH=4 and no drain, exactly four flits are accepted.
- R8: `fwd_last` and `loc_last` carry the tail flag (`in_last`) that the flit arrived with.
- R9: In any cycle, at most one of `fwd_valid` and `loc_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A multi-hop traversal ends here this cycle |
| in_data | input | DW | Flit payload |
| in_last | input | 1 | Flit is the packet tail |
| in_here | input | 1 | This router is the flit's destination |
| seg_ready | input | 1 | Next circuit segment is granted to this port (output not serving an earlier reservation) |
| dn_on | input | 1 | Downstream on/off line |
| loc_ready | input | 1 | Local core port accepts a flit |
| up_on | output | 1 | On/off line to the upstream router |
| fwd_valid | output | 1 | Flit continues toward the crossbar output |
| fwd_data | output | DW | Forwarded payload |
| fwd_last | output | 1 | Forwarded flit is a tail |
| fwd_from_buf | output | 1 | 1 = forwarded flit came from the buffer, 0 = from the latch |
| loc_valid | output | 1 | Flit delivered to the local core |
| loc_data | output | DW | Delivered payload |
| loc_last | output | 1 | Delivered flit is a tail |

## Verification
The bench targets four corner cases:
- A flit that arrives while an older one is still buffered. A design that prefers the latch would send it out of order and report it as bypassed.
- A destination flit arriving while the segment is free. A design that lets it bypass would emit it on the forward path.
- Filling the buffer while the segment is withheld. An `up_on` that is computed from the current occupancy rather than the next, or that is given no slack for the latched flit, would accept a fifth flit and lose data.
- A reset with flits held in the buffer. This checks that nothing is emitted afterwards and that `up_on` returns high.

// File: rtl/hop_inport_pkg.sv
package hop_inport_pkg;

  // Where a forwarded flit was taken from.
  typedef enum logic {
    SRC_LATCH = 1'b0,
    SRC_BUF   = 1'b1
  } fwd_src_e;

  // On/off decision: keep the line on only while more slots are free than
  // the number of flits that may still land after the line is sampled.
  function automatic logic space_ok(input int unsigned free_slots,
                                    input int unsigned slack);
    return free_slots > slack;
  endfunction

endpackage

// File: rtl/hop_latch.sv
module hop_latch #(
  parameter int FW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [FW-1:0] in_flit,
  output logic          lat_v,
  output logic [FW-1:0] lat_f
);

  logic          lat_v_d;
  logic [FW-1:0] lat_f_d;

  always_comb begin
    lat_v_d = in_valid;
    lat_f_d = lat_f;
    if (in_valid) lat_f_d = in_flit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_v <= 1'b0;
      lat_f <= '0;
    end else begin
      lat_v <= lat_v_d;
      lat_f <= lat_f_d;
    end
  end

endmodule

// File: rtl/hop_fifo.sv
module hop_fifo #(
  parameter int FW    = 10,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_flit,
  input  logic          rd_en,
  output logic [FW-1:0] head_flit,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count_next
);

  logic [FW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_d;
  logic [AW-1:0] rd_ptr, rd_ptr_d;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign head_flit = mem[rd_ptr];

  always_comb begin
    wr_ptr_d   = wr_en ? ptr_inc(wr_ptr) : wr_ptr;
    rd_ptr_d   = rd_en ? ptr_inc(rd_ptr) : rd_ptr;
    count_next = count + CW'(wr_en) - CW'(rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_next;
    end
  end

  // Storage carries no reset; only the pointers define validity.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_flit;
  end

  assert_no_overflow_R7 : assert property (
    @(posedge clk) disable iff (!rst_n) (wr_en && full) |-> rd_en)
    else $error("buffer written while full");

  assert_no_underflow_R3 : assert property (
    @(posedge clk) disable iff (!rst_n) rd_en |-> !empty)
    else $error("buffer read while empty");

endmodule

// File: rtl/hop_steer.sv
module hop_steer
  import hop_inport_pkg::*;
#(
  parameter int DW = 8,
  localparam int FW = DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_v,
  input  logic [FW-1:0] lat_f,
  input  logic          buf_empty,
  input  logic [FW-1:0] head_f,
  input  logic          seg_ready,
  input  logic          dn_on,
  input  logic          loc_ready,
  output logic          wr_en,
  output logic          rd_en,
  output logic          fwd_valid,
  output logic [FW-1:0] fwd_flit,
  output fwd_src_e      fwd_src,
  output logic          loc_valid,
  output logic [FW-1:0] loc_flit
);

  localparam int HERE_BIT = DW + 1;

  logic path_open;
  logic head_here, lat_here;
  logic head_go, bypass;

  always_comb begin
    path_open = seg_ready && dn_on;
    head_here = head_f[HERE_BIT];
    lat_here  = lat_f[HERE_BIT];

    // Buffer head first: keeps order and serves both output kinds.
    head_go = !buf_empty && (head_here ? loc_ready : path_open);
    // Latch skips the buffer only with nothing older waiting.
    bypass  = lat_v && buf_empty && !lat_here && path_open;

    wr_en = lat_v && !bypass;
    rd_en = head_go;

    fwd_valid = bypass || (head_go && !head_here);
    fwd_flit  = bypass ? lat_f : head_f;
    fwd_src   = bypass ? SRC_LATCH : SRC_BUF;
    loc_valid = head_go && head_here;
    loc_flit  = head_f;
  end

  assert_single_output_R9 : assert property (
    @(posedge clk) disable iff (!rst_n) !(fwd_valid && loc_valid))
    else $error("two outputs in one cycle");

  assert_fwd_gated_R4 : assert property (
    @(posedge clk) disable iff (!rst_n) fwd_valid |-> (dn_on && seg_ready))
    else $error("forward without permission");

  assert_latch_consumed_R2 : assert property (
    @(posedge clk) disable iff (!rst_n)
      lat_v |-> (wr_en || (fwd_valid && fwd_src == SRC_LATCH)))
    else $error("latched flit dropped");

  assert_order_kept_R6 : assert property (
    @(posedge clk) disable iff (!rst_n)
      (!buf_empty && fwd_valid) |-> (fwd_src == SRC_BUF))
    else $error("latch overtook buffer");

endmodule

// File: rtl/hop_onoff.sv
module hop_onoff
  import hop_inport_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int SLACK = 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_next,
  output logic          up_on
);

  logic up_on_d;

  always_comb begin
    up_on_d = space_ok(DEPTH - int'(count_next), SLACK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_on <= 1'b1;
    else        up_on <= up_on_d;
  end

endmodule

// File: rtl/hop_inport.sv
module hop_inport
  import hop_inport_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  input  logic          in_here,
  input  logic          seg_ready,
  input  logic          dn_on,
  input  logic          loc_ready,
  output logic          up_on,
  output logic          fwd_valid,
  output logic [DW-1:0] fwd_data,
  output logic          fwd_last,
  output logic          fwd_from_buf,
  output logic          loc_valid,
  output logic [DW-1:0] loc_data,
  output logic          loc_last
);

  localparam int FW    = DW + 2;
  localparam int CW    = $clog2(DEPTH + 1);
  // One flit can still sit in the latch once upstream sees the line drop.
  localparam int SLACK = 1;

  logic          lat_v;
  logic [FW-1:0] lat_f;
  logic [FW-1:0] head_f, fwd_flit, loc_flit;
  logic          buf_empty, buf_full;
  logic          wr_en, rd_en;
  logic [CW-1:0] count_next;
  fwd_src_e      fwd_src;

  hop_latch #(.FW(FW)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_flit  ({in_here, in_last, in_data}),
    .lat_v    (lat_v),
    .lat_f    (lat_f)
  );

  hop_fifo #(.FW(FW), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_flit    (lat_f),
    .rd_en      (rd_en),
    .head_flit  (head_f),
    .empty      (buf_empty),
    .full       (buf_full),
    .count_next (count_next)
  );

  hop_steer #(.DW(DW)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .lat_v     (lat_v),
    .lat_f     (lat_f),
    .buf_empty (buf_empty),
    .head_f    (head_f),
    .seg_ready (seg_ready),
    .dn_on     (dn_on),
    .loc_ready (loc_ready),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .fwd_valid (fwd_valid),
    .fwd_flit  (fwd_flit),
    .fwd_src   (fwd_src),
    .loc_valid (loc_valid),
    .loc_flit  (loc_flit)
  );

  hop_onoff #(.DEPTH(DEPTH), .SLACK(SLACK)) u_onoff (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_next (count_next),
    .up_on      (up_on)
  );

  assign fwd_data     = fwd_flit[DW-1:0];
  assign fwd_last     = fwd_flit[DW];
  assign fwd_from_buf = (fwd_src == SRC_BUF);
  assign loc_data     = loc_flit[DW-1:0];
  assign loc_last     = loc_flit[DW];

  assert_full_means_off_R7 : assert property (
    @(posedge clk) disable iff (!rst_n) buf_full |-> !up_on)
    else $error("upstream line on with full buffer");

  assert_dest_not_forwarded_R5 : assert property (
    @(posedge clk) disable iff (!rst_n)
      (fwd_valid && fwd_src == SRC_BUF) |-> !head_f[DW+1])
    else $error("destination flit forwarded");

endmodule

// File: tb/hop_inport_tb_top.sv
module hop_inport_tb_top;

  localparam int DW    = 8;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_last, in_here;
  logic [DW-1:0] in_data;
  logic          seg_ready, dn_on, loc_ready;
  logic          up_on, fwd_valid, fwd_last, fwd_from_buf;
  logic [DW-1:0] fwd_data, loc_data;
  logic          loc_valid, loc_last;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  hop_inport #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_last      (in_last),
    .in_here      (in_here),
    .seg_ready    (seg_ready),
    .dn_on        (dn_on),
    .loc_ready    (loc_ready),
    .up_on        (up_on),
    .fwd_valid    (fwd_valid),
    .fwd_data     (fwd_data),
    .fwd_last     (fwd_last),
    .fwd_from_buf (fwd_from_buf),
    .loc_valid    (loc_valid),
    .loc_data     (loc_data),
    .loc_last     (loc_last)
  );

  typedef struct packed {
    logic       iv;
    logic [7:0] id;
    logic       il, ih, sr, dn, lr;
    logic       fv;
    logic [7:0] fd;
    logic       fl, fb, lv;
    logic [7:0] ld;
    logic       ll, up;
  } vec_t;

  localparam int NV = 13;
  // Inputs of the cycle | outputs expected in that same cycle.
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'hA1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    '{1'b1, 8'hA2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,  1'b1, 8'hA1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    '{1'b1, 8'hA3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,  1'b1, 8'hA2, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,  1'b1, 8'hA3, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
    '{1'b1, 8'hB1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    '{1'b1, 8'hC1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,  1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hB1, 1'b1, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,  1'b1, 8'hC1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; in_here = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int sent;
    rst_n = 1'b0;
    idle_inputs();
    seg_ready = 1'b1; dn_on = 1'b1; loc_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 up_on in reset", up_on, 1'b1);
    chk("R1 fwd_valid in reset", fwd_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 loc_valid after reset", loc_valid, 1'b0);
    chk("R1 fwd_valid after reset", fwd_valid, 1'b0);

    // Table walk: R2 bypass, R3 seg hold, R4 dn off, R5 local, R6 order, R8 tail.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = TBL[i].iv; in_data = TBL[i].id; in_last = TBL[i].il;
      in_here = TBL[i].ih; seg_ready = TBL[i].sr; dn_on = TBL[i].dn;
      loc_ready = TBL[i].lr;
      #1;
      chk($sformatf("R2/R3/R4 fwd_valid row %0d", i), fwd_valid, TBL[i].fv);
      chk($sformatf("R5/R9 loc_valid row %0d", i), loc_valid, TBL[i].lv);
      chk($sformatf("R7 up_on row %0d", i), up_on, TBL[i].up);
      if (TBL[i].fv) begin
        chk($sformatf("R6 fwd_data row %0d", i), fwd_data, TBL[i].fd);
        chk($sformatf("R8 fwd_last row %0d", i), fwd_last, TBL[i].fl);
        chk($sformatf("R2/R3 fwd_from_buf row %0d", i), fwd_from_buf, TBL[i].fb);
      end
      if (TBL[i].lv) begin
        chk($sformatf("R5 loc_data row %0d", i), loc_data, TBL[i].ld);
        chk($sformatf("R8 loc_last row %0d", i), loc_last, TBL[i].ll);
      end
    end

    // R7: fill with the segment withheld, sending only while up_on is 1.
    @(negedge clk);
    idle_inputs();
    seg_ready = 1'b0; dn_on = 1'b1; loc_ready = 1'b0;
    sent = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (up_on) begin
        in_valid = 1'b1; in_data = 8'h10 + 8'(sent); sent++;
      end else begin
        in_valid = 1'b0;
      end
    end
    #1;
    chk("R7 flits accepted before off", sent, DEPTH);
    chk("R7 up_on low when full", up_on, 1'b0);
    in_valid = 1'b0;

    // R4: head waits while the downstream line is off.
    @(negedge clk);
    seg_ready = 1'b1; dn_on = 1'b0;
    #1;
    chk("R4 no forward with dn_on low", fwd_valid, 1'b0);

    dn_on = 1'b1;
    for (int j = 0; j < DEPTH; j++) begin
      if (j != 0) @(negedge clk);
      #1;
      chk("R3 drain fwd_valid", fwd_valid, 1'b1);
      chk("R6 drain order", fwd_data, 8'h10 + 8'(j));
      chk("R3 drain from buffer", fwd_from_buf, 1'b1);
    end
    @(negedge clk); #1;
    chk("R7 up_on back on after drain", up_on, 1'b1);
    chk("R3 buffer empty after drain", fwd_valid, 1'b0);

    // R1: reset with flits buffered clears them.
    seg_ready = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h55 + 8'(k);
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; seg_ready = 1'b1; loc_ready = 1'b1;
    #1;
    chk("R1 up_on during mid reset", up_on, 1'b1);
    chk("R1 no forward during mid reset", fwd_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 buffer cleared by reset", fwd_valid, 1'b0);
    chk("R1 no local after reset", loc_valid, 1'b0);

    finish_run();
  end

endmodule